// File: doc/BRIEF.md
# Frame-Transfer CCD Clock Sequencer

This block produces every drive clock that a frame-transfer area image sensor needs, all timed from a single fast master clock. A frame-level mode machine alternates between two phases. In the frame-transfer phase the whole image is moved from the photosensitive section into the storage section. In the integration/readout phase the stored image is read out line by line. The frame clock output shows which phase is active.

Each readout line has two parts. A reverse segment comes first: the storage-section clocks move the stored image one row toward the horizontal readout register, and the readout-register clocks stay still. A forward segment follows: the readout-register clocks shift the row out one pixel per pixel period, an output-stage reset pulse marks each pixel, and the storage clocks stay still.

Every four-phase clock set comes from one 8-count counter. Each phase is a copy of a 5-high/3-low pulse, shifted two counts from its neighbour. After the last line there is a programmable idle pad, which sets the overall frame rate. Line and frame marker pulses let downstream capture logic line up with the sensor output.

Top module: `ccd_clock_seq`

## Requirements
- R1: While rst_n is low at a rising clock edge, the sequencer enters frame transfer with every counter cleared. The outputs then read frame_clk=0, img_ph=stor_ph=4'b1101, rd_clk_a=0, rd_clk_b=1, ob_rst=0, line_mark=0 and frame_mark=0.
- R2: After reset, and after each idle pad, frame_clk stays low for exactly 8*XFER_CYCLES master clocks. It then stays high until the next transfer starts. line_mark never pulses while frame_clk is low.
- R3: During frame transfer, img_ph and stor_ph run together from one 8-count value c, which starts at 0. Bit k is high when (c - 2k) mod 8 is less than 5, giving a 5:3 duty with a 2-count shift between neighbours. Exactly one phase bit changes per master clock.
- R4: While frame_clk is high, img_ph holds 4'b1101 (the count-0 levels) without change.
- R5: Each line starts with a reverse segment of 8*ROW_SHIFT_CYCLES clocks. In it, stor_ph runs the R3 pattern from count 0 and completes whole 8-count cycles. rd_clk_a is held at 0 and rd_clk_b at 1.
- R6: The forward segment follows and lasts PIX_PER_LINE pixel periods of 4 master clocks each. rd_clk_a is high for the first two clocks of each pixel period and rd_clk_b is its complement. stor_ph holds 4'b1101.
- R7: ob_rst is high for the first master clock of every forward-segment pixel period, which divides the master clock by four. It is low everywhere else.
- R8: line_mark is high for one clock, on the last clock of each line's forward segment. Each frame has LINES_PER_FRAME lines, and each new line begins with its reverse segment.
- R9: frame_mark is high together with the line_mark of the last line. Next comes an idle pad of PAD_CLKS clocks with frame_clk high and all clocks at their held levels (img_ph=stor_ph=4'b1101, rd_clk_a=0, rd_clk_b=1, ob_rst=0). Then the next frame transfer starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous reset, active low |
| frame_clk | output | 1 | High during integration/readout and pad, low during frame transfer |
| img_ph | output | 4 | Image-section four-phase transfer clocks |
| stor_ph | output | 4 | Storage-section four-phase line-transfer clocks |
| rd_clk_a | output | 1 | Readout-register clock, first phase |
| rd_clk_b | output | 1 | Readout-register clock, complement of rd_clk_a |
| ob_rst | output | 1 | Output-stage reset pulse, one per pixel period |
| line_mark | output | 1 | One-clock pulse on the last clock of each line |
| frame_mark | output | 1 | One-clock pulse on the last clock of the last line |

## Verification
A phase counter that slips or skips shows on the ports in the same master clock: two phase bits change together, or the four-phase pattern departs from the shifted 5:3 shape. A wrong pixel or sub-pixel count moves line_mark and the readout-clock pattern within one line. A line or transfer counter that is off by one moves frame_mark, and the fall of frame_clk, by a whole line or a whole 8-count cycle. That error shows before the end of the frame in which it occurs. The reference model predicts every output on every clock over several frames and across a reset in mid-frame, so a single-clock mismatch is caught.

// File: rtl/ccd_seq_pkg.sv
// Package: shared mode and line-segment encodings for the CCD clock sequencer.
// Assumes: used by ccd_line_timer and ccd_clock_seq only.
package ccd_seq_pkg;

    // Frame-level operating mode
    typedef enum logic [1:0] {
        MODE_XFER = 2'd0,
        MODE_READ = 2'd1,
        MODE_PAD  = 2'd2
    } seq_mode_t;

    // Part of a readout line
    typedef enum logic {
        SEG_REV = 1'b0,
        SEG_FWD = 1'b1
    } line_seg_t;

endpackage

// File: rtl/ccd_phase_gen.sv
// Module: multi-phase clock generator.
// One STEPS-count counter advances while en is high. Phase k is high when
// (count - k*SHIFT) mod STEPS is less than HIGH. While en is low the counter
// holds, so the phases hold their levels.
// Assumes: NUM_PH*SHIFT == STEPS and every rising and falling edge falls on a
// distinct count. This gives exactly one phase edge per step (true for 4/8/5/2).
module ccd_phase_gen #(
    parameter int NUM_PH = 4,
    parameter int STEPS  = 8,
    parameter int HIGH   = 5,
    parameter int SHIFT  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    output logic [NUM_PH-1:0] ph,
    output logic              wrap
);
    localparam int CW = (STEPS > 1) ? $clog2(STEPS) : 1;

    logic [CW-1:0] cnt;

    // Step counter: advances while enabled, wraps after STEPS counts
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (en) begin
            cnt <= (cnt == CW'(STEPS - 1)) ? '0 : cnt + 1'b1;
        end
    end

    assign wrap = en && (cnt == CW'(STEPS - 1));

    // One decoder per phase, each offset by k*SHIFT counts
    for (genvar k = 0; k < NUM_PH; k++) begin : g_ph
        localparam int OFS = (STEPS - ((k * SHIFT) % STEPS)) % STEPS;
        logic [CW:0] pos_sum;
        logic [CW:0] pos;
        assign pos_sum = {1'b0, cnt} + (CW+1)'(OFS);
        assign pos     = (pos_sum >= (CW+1)'(STEPS)) ? pos_sum - (CW+1)'(STEPS) : pos_sum;
        assign ph[k]   = (pos < (CW+1)'(HIGH));
    end

    // R3
    single_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(en) && $past(rst_n)) |-> ($countones(ph ^ $past(ph)) == 1));

endmodule

// File: rtl/ccd_line_timer.sv
// Module: line loop for readout.
// While run is high it repeats a line made of a reverse segment of REV_CLKS
// clocks, then a forward segment of PIX pixel periods of SUB clocks each.
// While run is low it sits at the start of a reverse segment.
// Assumes: SUB is even. The readout clock is high for the first SUB/2 clocks of
// each pixel period.
module ccd_line_timer
    import ccd_seq_pkg::*;
#(
    parameter int PIX      = 1056,
    parameter int REV_CLKS = 8,
    parameter int SUB      = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic row_shift,
    output logic rd_a,
    output logic rst_pulse,
    output logic line_end
);
    localparam int RW = (REV_CLKS > 1) ? $clog2(REV_CLKS) : 1;
    localparam int PW = (PIX > 1) ? $clog2(PIX) : 1;
    localparam int SW = (SUB > 1) ? $clog2(SUB) : 1;

    line_seg_t     seg;
    logic [RW-1:0] rev_cnt;
    logic [PW-1:0] pix_cnt;
    logic [SW-1:0] sub_cnt;
    logic          fwd;

    // Segment sequencing: reverse clocks, then pixel periods, then repeat
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            seg     <= SEG_REV;
            rev_cnt <= '0;
            pix_cnt <= '0;
            sub_cnt <= '0;
        end else if (seg == SEG_REV) begin
            if (rev_cnt == RW'(REV_CLKS - 1)) begin
                rev_cnt <= '0;
                seg     <= SEG_FWD;
            end else begin
                rev_cnt <= rev_cnt + 1'b1;
            end
        end else if (sub_cnt == SW'(SUB - 1)) begin
            sub_cnt <= '0;
            if (pix_cnt == PW'(PIX - 1)) begin
                pix_cnt <= '0;
                seg     <= SEG_REV;
            end else begin
                pix_cnt <= pix_cnt + 1'b1;
            end
        end else begin
            sub_cnt <= sub_cnt + 1'b1;
        end
    end

    // Decode segment outputs
    assign fwd       = run && (seg == SEG_FWD);
    assign row_shift = run && (seg == SEG_REV);
    assign rd_a      = fwd && (sub_cnt < SW'(SUB / 2));
    assign rst_pulse = fwd && (sub_cnt == '0);
    assign line_end  = fwd && (pix_cnt == PW'(PIX - 1)) && (sub_cnt == SW'(SUB - 1));

    // R8
    line_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_end |=> (seg == SEG_REV && rev_cnt == '0 && pix_cnt == '0));

endmodule

// File: rtl/ccd_clock_seq.sv
// Module: top of the frame-transfer CCD clock sequencer.
// A mode machine cycles through frame transfer, line readout and an idle pad.
// Image clocks run only in transfer. Storage clocks run in transfer and in each
// line's reverse segment.
// Assumes: every count parameter is at least 1 except PAD_CLKS, which may be 0.
module ccd_clock_seq
    import ccd_seq_pkg::*;
#(
    parameter int PIX_PER_LINE     = 1056,
    parameter int LINES_PER_FRAME  = 1056,
    parameter int XFER_CYCLES      = 1056,
    parameter int ROW_SHIFT_CYCLES = 1,
    parameter int PAD_CLKS         = 522560
) (
    input  logic       clk,
    input  logic       rst_n,
    output logic       frame_clk,
    output logic [3:0] img_ph,
    output logic [3:0] stor_ph,
    output logic       rd_clk_a,
    output logic       rd_clk_b,
    output logic       ob_rst,
    output logic       line_mark,
    output logic       frame_mark
);
    localparam int NUM_PH   = 4;
    localparam int STEPS    = 8;
    localparam int SUB      = 4;
    localparam int REV_CLKS = STEPS * ROW_SHIFT_CYCLES;
    localparam int XW  = (XFER_CYCLES > 1) ? $clog2(XFER_CYCLES) : 1;
    localparam int LW  = (LINES_PER_FRAME > 1) ? $clog2(LINES_PER_FRAME) : 1;
    localparam int PDW = (PAD_CLKS > 1) ? $clog2(PAD_CLKS) : 1;

    seq_mode_t      mode;
    logic [XW-1:0]  xfer_cnt;
    logic [LW-1:0]  line_cnt;
    logic [PDW-1:0] pad_cnt;
    logic           img_en, stor_en, img_wrap, stor_wrap;
    logic           row_shift, line_end, rd_a, rst_pulse, run;

    assign run     = (mode == MODE_READ);
    assign img_en  = (mode == MODE_XFER);
    assign stor_en = img_en || row_shift;

    ccd_phase_gen #(.NUM_PH(NUM_PH), .STEPS(STEPS), .HIGH(5), .SHIFT(2)) u_img (
        .clk(clk), .rst_n(rst_n), .en(img_en), .ph(img_ph), .wrap(img_wrap)
    );

    ccd_phase_gen #(.NUM_PH(NUM_PH), .STEPS(STEPS), .HIGH(5), .SHIFT(2)) u_stor (
        .clk(clk), .rst_n(rst_n), .en(stor_en), .ph(stor_ph), .wrap(stor_wrap)
    );

    ccd_line_timer #(.PIX(PIX_PER_LINE), .REV_CLKS(REV_CLKS), .SUB(SUB)) u_line (
        .clk(clk), .rst_n(rst_n), .run(run), .row_shift(row_shift),
        .rd_a(rd_a), .rst_pulse(rst_pulse), .line_end(line_end)
    );

    // Frame mode machine: transfer cycles, line count, pad clocks
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode     <= MODE_XFER;
            xfer_cnt <= '0;
            line_cnt <= '0;
            pad_cnt  <= '0;
        end else begin
            case (mode)
                MODE_XFER: if (img_wrap) begin
                    if (xfer_cnt == XW'(XFER_CYCLES - 1)) begin
                        xfer_cnt <= '0;
                        mode     <= MODE_READ;
                    end else begin
                        xfer_cnt <= xfer_cnt + 1'b1;
                    end
                end
                MODE_READ: if (line_end) begin
                    if (line_cnt == LW'(LINES_PER_FRAME - 1)) begin
                        line_cnt <= '0;
                        mode     <= (PAD_CLKS > 0) ? MODE_PAD : MODE_XFER;
                    end else begin
                        line_cnt <= line_cnt + 1'b1;
                    end
                end
                MODE_PAD: begin
                    if (pad_cnt == PDW'(PAD_CLKS - 1)) begin
                        pad_cnt <= '0;
                        mode    <= MODE_XFER;
                    end else begin
                        pad_cnt <= pad_cnt + 1'b1;
                    end
                end
                default: mode <= MODE_XFER;
            endcase
        end
    end

    // Output drive
    assign frame_clk  = (mode != MODE_XFER);
    assign rd_clk_a   = rd_a;
    assign rd_clk_b   = ~rd_a;
    assign ob_rst     = rst_pulse;
    assign line_mark  = line_end;
    assign frame_mark = line_end && (line_cnt == LW'(LINES_PER_FRAME - 1));

    // R2
    no_line_in_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_clk |-> !line_mark);

    // R4
    img_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_clk && $past(frame_clk) && $past(rst_n)) |-> $stable(img_ph));

    // R5
    whole_row_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(row_shift) && run) |-> $past(stor_wrap));

    // R7
    reset_in_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ob_rst |-> rd_clk_a);

    // R9
    frame_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_mark |=> (line_cnt == '0 && frame_clk == (PAD_CLKS > 0)));

endmodule

// File: tb/ccd_clock_seq_tb.sv
module ccd_clock_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int P   = 6;
    localparam int NL  = 4;
    localparam int XC  = 3;
    localparam int RSC = 1;
    localparam int PAD = 5;
    localparam int REV = 8 * RSC;
    localparam int LEN = REV + 4 * P;
    localparam int FRM = 8 * XC + NL * LEN + PAD;

    // ctx: 0 reset, 1 transfer, 2 reverse, 3 forward, 4 pad
    typedef struct packed {
        logic [2:0] ctx;
        logic       fc;
        logic [3:0] img;
        logic [3:0] stor;
        logic       ra;
        logic       rb;
        logic       orst;
        logic       lm;
        logic       fm;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic       frame_clk, rd_clk_a, rd_clk_b, ob_rst, line_mark, frame_mark;
    logic [3:0] img_ph, stor_ph;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    exp_t exp_q[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    ccd_clock_seq #(
        .PIX_PER_LINE(P), .LINES_PER_FRAME(NL), .XFER_CYCLES(XC),
        .ROW_SHIFT_CYCLES(RSC), .PAD_CLKS(PAD)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .frame_clk(frame_clk), .img_ph(img_ph),
        .stor_ph(stor_ph), .rd_clk_a(rd_clk_a), .rd_clk_b(rd_clk_b),
        .ob_rst(ob_rst), .line_mark(line_mark), .frame_mark(frame_mark)
    );

    function automatic logic [3:0] ph_at(int c);
        logic [3:0] v;
        for (int k = 0; k < 4; k++) v[k] = (((c + 8 - 2 * k) % 8) < 5);
        return v;
    endfunction

    // Reference model: expected outputs n clocks after reset release
    function automatic exp_t exp_at(int n);
        exp_t e;
        int f = n % FRM;
        e = '0;
        e.rb = 1'b1;
        e.fc = 1'b1;
        e.img = ph_at(0);
        e.stor = ph_at(0);
        if (f < 8 * XC) begin
            e.ctx = 3'd1; e.fc = 1'b0;
            e.img = ph_at(f % 8); e.stor = ph_at(f % 8);
        end else if (f < 8 * XC + NL * LEN) begin
            int g = f - 8 * XC;
            int ln = g / LEN;
            int o = g % LEN;
            if (o < REV) begin
                e.ctx = 3'd2; e.stor = ph_at(o % 8);
            end else begin
                int m = o - REV;
                int q = m % 4;
                e.ctx = 3'd3;
                e.ra = (q < 2); e.rb = !(q < 2);
                e.orst = (q == 0);
                e.lm = (m == 4 * P - 1);
                e.fm = e.lm && (ln == NL - 1);
            end
        end else begin
            e.ctx = 3'd4;
        end
        return e;
    endfunction

    function automatic exp_t reset_item();
        exp_t e = '0;
        e.img = 4'b1101; e.stor = 4'b1101; e.rb = 1'b1;
        return e;
    endfunction

    function automatic string tag_of(string fld, logic [2:0] ctx);
        if (ctx == 3'd0) return "R1";
        case (fld)
            "fc":   return (ctx == 3'd4) ? "R9" : "R2";
            "img":  return (ctx == 3'd1) ? "R3" : "R4";
            "stor": return (ctx == 3'd1) ? "R3" : (ctx == 3'd2) ? "R5" : (ctx == 3'd3) ? "R6" : "R9";
            "rd":   return (ctx == 3'd1) ? "R2" : (ctx == 3'd2) ? "R5" : (ctx == 3'd3) ? "R6" : "R9";
            "orst": return "R7";
            "lm":   return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic chk(string tg, string fld, logic [3:0] act, logic [3:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s at %0t: actual=%0h expected=%0h", tg, fld, $time, act, exp);
        end
    endtask

    task automatic push_run(int n);
        for (int i = 0; i < n; i++) exp_q.push_back(exp_at(i));
    endtask

    task automatic report();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // Monitor: pops one expected item per clock and compares every output
    initial begin
        forever begin
            exp_t e;
            @(negedge clk);
            #1;
            if (exp_q.size() > 0) begin
                e = exp_q.pop_front();
                chk(tag_of("fc", e.ctx), "frame_clk", {3'b0, frame_clk}, {3'b0, e.fc});
                chk(tag_of("img", e.ctx), "img_ph", img_ph, e.img);
                chk(tag_of("stor", e.ctx), "stor_ph", stor_ph, e.stor);
                chk(tag_of("rd", e.ctx), "rd_clk", {2'b0, rd_clk_a, rd_clk_b}, {2'b0, e.ra, e.rb});
                chk(tag_of("orst", e.ctx), "ob_rst", {3'b0, ob_rst}, {3'b0, e.orst});
                chk(tag_of("lm", e.ctx), "line_mark", {3'b0, line_mark}, {3'b0, e.lm});
                chk(tag_of("fm", e.ctx), "frame_mark", {3'b0, frame_mark}, {3'b0, e.fm});
            end
        end
    end

    // Driver: reset (R1), two full frames plus part of a third, reset mid-frame, one more frame
    initial begin
        rst_n = 1'b0;
        @(negedge clk); exp_q.push_back(reset_item());
        @(negedge clk); exp_q.push_back(reset_item());
        @(negedge clk); rst_n = 1'b1;
        push_run(2 * FRM + 8 * XC + LEN + 13);
        wait (exp_q.size() == 0);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); exp_q.push_back(reset_item());
        @(negedge clk); exp_q.push_back(reset_item());
        @(negedge clk); rst_n = 1'b1;
        push_run(FRM + 10);
        wait (exp_q.size() == 0);
        @(negedge clk);
        done = 1'b1;
        report();
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R8 watchdog: actual=running expected=finished");
            report();
        end
    end
endmodule